// File: doc/BRIEF.md
# External Interrupt Sense Detector

This block watches a single external interrupt pin and turns its activity into an interrupt request. A 2-bit sense code picks the condition: a low level on the pin, any change of the pin, a falling edge or a rising edge. The pin first passes through a two-flop synchroniser. Edges are found by comparing the synchronised value with its value one clock earlier. Edge and change events set a sticky request flag. The CPU clears that flag with an acknowledge pulse, or the flag clears when the interrupt is taken. A low-level request is not held and simply follows the pin. The request reaches the CPU line only when both the global interrupt enable and this pin's mask bit are 1.

For the deepest sleep state, where the system clock is stopped, a separate wake qualifier runs on a slow free-running clock. It accepts a low level, or a change away from the level the pin had when sleep began. The condition must hold on two successive slow-clock samples. A short glitch therefore cannot wake the system.

Top module: `ext_irq_sense`

## Requirements
- R1: While reset is asserted, and after it is released with the pin idle high, `req_flag`, `irq_line` and `wake_req` are 0.
- R2: With sense code 2'b00 (low level), `req_flag` is 1 exactly while the synchronised pin is low. It rises two clock edges after the pin falls and drops two edges after the pin rises. It is never latched: an acknowledge does not clear it, and the sticky flag is emptied while this code is active.
- R3: With sense code 2'b01 (any change), both a falling and a rising pin transition set the sticky flag, visible three clock edges after the pin moves.
- R4: With sense code 2'b10, only a falling transition sets the flag; a rising one does not.
- R5: With sense code 2'b11, only a rising transition sets the flag; a falling one does not.
- R6: The sticky flag is cleared by a one-cycle `flag_clr` or `irq_taken`. When a new event and a clear fall on the same edge, the event wins and the flag stays 1.
- R7: `irq_line` is 1 only when `req_flag`, `pin_mask` and `glob_ie` are all 1.
- R8: With `pin_mask` at 0, edge events still set `req_flag` and still update the edge history. After the flag is cleared, setting the mask produces no request from an edge that happened while masked.
- R9: A new sense code takes effect from the clock edge after it is applied. Changing the code while the pin is steady creates no request.
- R10: In deep sleep with code 2'b00 and the mask set, `wake_req` rises once the pin has been low on two successive slow-clock samples. A low pulse shorter than one slow period does not wake.
- R11: In deep sleep with code 2'b01 and the mask set, `wake_req` rises once the pin has differed, on two successive slow samples, from the level it had when sleep was entered.
- R12: `wake_req` stays 0 under edge codes (2'b10, 2'b11), with the mask cleared, or outside deep sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_clk | input | 1 | Free-running slow clock for the wake qualifier |
| pin_in | input | 1 | External interrupt pin, asynchronous |
| sense_sel | input | 2 | Sense code: 00 low level, 01 any change, 10 falling, 11 rising |
| pin_mask | input | 1 | Mask bit for this pin |
| glob_ie | input | 1 | Global interrupt enable |
| flag_clr | input | 1 | CPU acknowledge pulse, clears the sticky flag |
| irq_taken | input | 1 | Pulse when the interrupt is taken, clears the sticky flag |
| deep_sleep | input | 1 | High while the system is in its deepest sleep |
| req_flag | output | 1 | Request flag (level-following or sticky) |
| irq_line | output | 1 | Gated interrupt line to the CPU |
| wake_req | output | 1 | Qualified wake request from the slow domain |

## Verification
The hardest case to reach from the ports is an edge event and a flag clear landing on the same clock edge. That edge arrives only after the synchroniser and history registers have moved. The bench counts the pin's two synchroniser edges and raises `flag_clr` for exactly the third edge. It does the same with a sense-code change while the pin is steady, and with a return from level mode. The purpose is to show that no stale sticky state leaks through. The slow-domain glitch rejection is reached with a low pulse shorter than one slow-clock period.

// File: rtl/eis_pkg.sv
package eis_pkg;
  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_ANY  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_e;
endpackage

// File: rtl/eis_rst_sync.sv
module eis_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain_q;
  logic [LAST:0] chain_d;

  always_comb begin
    chain_d = {chain_q[LAST-1:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_n_o = chain_q[LAST];
endmodule

// File: rtl/eis_pin_sync.sv
module eis_pin_sync #(
  parameter int   STAGES = 2,
  parameter logic IDLE   = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic q_out
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] stage_q;
  logic [LAST:0] stage_d;

  always_comb begin
    stage_d = {stage_q[LAST-1:0], d_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= {STAGES{IDLE}};
    else        stage_q <= stage_d;
  end

  assign q_out = stage_q[LAST];
endmodule

// File: rtl/eis_edge_track.sv
module eis_edge_track
  import eis_pkg::*;
#(
  parameter logic IDLE = 1'b1
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   pin_s,
  input  sense_e mode_in,
  input  logic   flag_clr,
  input  logic   irq_taken,
  output logic   req_flag
);
  sense_e mode_q, mode_d;
  logic   prev_q, prev_d;
  logic   sticky_q, sticky_d;
  logic   rise, fall, hit, clr_any;

  // Edge finders against the history register
  always_comb begin
    rise    = pin_s & ~prev_q;
    fall    = ~pin_s & prev_q;
    clr_any = flag_clr | irq_taken;
    unique case (mode_q)
      SENSE_ANY:  hit = rise | fall;
      SENSE_FALL: hit = fall;
      SENSE_RISE: hit = rise;
      default:    hit = 1'b0;
    endcase
  end

  // Next state: code registered, history always tracks, event beats clear
  always_comb begin
    mode_d = mode_in;
    prev_d = pin_s;
    if (mode_q == SENSE_LOW) sticky_d = 1'b0;
    else if (hit)            sticky_d = 1'b1;
    else if (clr_any)        sticky_d = 1'b0;
    else                     sticky_d = sticky_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= SENSE_LOW;
      prev_q   <= IDLE;
      sticky_q <= 1'b0;
    end else begin
      mode_q   <= mode_d;
      prev_q   <= prev_d;
      sticky_q <= sticky_d;
    end
  end

  assign req_flag = (mode_q == SENSE_LOW) ? ~pin_s : sticky_q;

  // R6
  clr_no_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag_clr || irq_taken) && (pin_s == prev_q)) |=> !sticky_q);

  // R2
  lvl_unlatched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == SENSE_LOW) |=> !sticky_q);

  // R4
  fall_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == SENSE_FALL) && !sticky_q && !(prev_q && !pin_s)) |=> !sticky_q);

  // R5
  rise_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == SENSE_RISE) && !sticky_q && !(!prev_q && pin_s)) |=> !sticky_q);
endmodule

// File: rtl/eis_wake_qual.sv
module eis_wake_qual
  import eis_pkg::*;
#(
  parameter int   SAMPLES = 2,
  parameter logic IDLE    = 1'b1
) (
  input  logic   slow_clk,
  input  logic   rst_n,
  input  logic   pin_in,
  input  sense_e mode_in,
  input  logic   pin_mask,
  input  logic   deep_sleep,
  output logic   wake_req
);
  localparam int LAST = SAMPLES - 1;

  logic [LAST:0] smp_q, smp_d;
  logic          ref_q, ref_d;
  logic          wake_q, wake_d;
  logic          all_low, all_moved, cond;

  always_comb begin
    if (SAMPLES > 1) smp_d = {smp_q[LAST-1:0], pin_in};
    else             smp_d = {SAMPLES{pin_in}};
    ref_d     = deep_sleep ? ref_q : smp_q[0];
    all_low   = ~|smp_q;
    all_moved = &(smp_q ^ {SAMPLES{ref_q}});
    unique case (mode_in)
      SENSE_LOW: cond = all_low;
      SENSE_ANY: cond = all_moved;
      default:   cond = 1'b0;
    endcase
    wake_d = deep_sleep & pin_mask & cond;
  end

  always_ff @(posedge slow_clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q  <= {SAMPLES{IDLE}};
      ref_q  <= IDLE;
      wake_q <= 1'b0;
    end else begin
      smp_q  <= smp_d;
      ref_q  <= ref_d;
      wake_q <= wake_d;
    end
  end

  assign wake_req = wake_q;

  // R12
  edge_nowake_chk: assert property (@(posedge slow_clk) disable iff (!rst_n)
    mode_in[1] |=> !wake_q);

  // R12
  awake_nowake_chk: assert property (@(posedge slow_clk) disable iff (!rst_n)
    wake_q |-> $past(deep_sleep));
endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
  import eis_pkg::*;
#(
  parameter int   SYNC_STAGES  = 2,
  parameter int   RST_STAGES   = 2,
  parameter int   WAKE_SAMPLES = 2,
  parameter logic PIN_IDLE     = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       slow_clk,
  input  logic       pin_in,
  input  logic [1:0] sense_sel,
  input  logic       pin_mask,
  input  logic       glob_ie,
  input  logic       flag_clr,
  input  logic       irq_taken,
  input  logic       deep_sleep,
  output logic       req_flag,
  output logic       irq_line,
  output logic       wake_req
);
  logic   fast_rst_n, slow_rst_n;
  logic   pin_s;
  sense_e mode;

  assign mode = sense_e'(sense_sel);

  eis_rst_sync #(.STAGES(RST_STAGES)) u_fast_rst (
    .clk(clk), .arst_n(rst_n), .rst_n_o(fast_rst_n));

  eis_rst_sync #(.STAGES(RST_STAGES)) u_slow_rst (
    .clk(slow_clk), .arst_n(rst_n), .rst_n_o(slow_rst_n));

  eis_pin_sync #(.STAGES(SYNC_STAGES), .IDLE(PIN_IDLE)) u_pin_sync (
    .clk(clk), .rst_n(fast_rst_n), .d_in(pin_in), .q_out(pin_s));

  eis_edge_track #(.IDLE(PIN_IDLE)) u_edge (
    .clk(clk), .rst_n(fast_rst_n), .pin_s(pin_s), .mode_in(mode),
    .flag_clr(flag_clr), .irq_taken(irq_taken), .req_flag(req_flag));

  eis_wake_qual #(.SAMPLES(WAKE_SAMPLES), .IDLE(PIN_IDLE)) u_wake (
    .slow_clk(slow_clk), .rst_n(slow_rst_n), .pin_in(pin_in),
    .mode_in(mode), .pin_mask(pin_mask), .deep_sleep(deep_sleep),
    .wake_req(wake_req));

  assign irq_line = req_flag & pin_mask & glob_ie;

  // R7
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!fast_rst_n)
    (!pin_mask || !glob_ie) |-> !irq_line);
endmodule

// File: tb/ext_irq_sense_bench.sv
module ext_irq_sense_bench;
  logic clk = 1'b0;
  logic slow_clk = 1'b0;
  logic rst_n, pin_in, pin_mask, glob_ie, flag_clr, irq_taken, deep_sleep;
  logic [1:0] sense_sel;
  logic req_flag, irq_line, wake_req;
  int n_chk = 0;
  int n_fail = 0;

  always #4  clk = ~clk;
  always #40 slow_clk = ~slow_clk;

  ext_irq_sense u_ext_irq_sense (
    .clk(clk), .rst_n(rst_n), .slow_clk(slow_clk), .pin_in(pin_in),
    .sense_sel(sense_sel), .pin_mask(pin_mask), .glob_ie(glob_ie),
    .flag_clr(flag_clr), .irq_taken(irq_taken), .deep_sleep(deep_sleep),
    .req_flag(req_flag), .irq_line(irq_line), .wake_req(wake_req));

  // {code[1:0], mask, gie, pin_start, pin_end, exp_flag, exp_line}
  localparam logic [7:0] VEC [0:11] = '{
    8'b00111011, 8'b00110100, 8'b01111011, 8'b01110111,
    8'b01111100, 8'b10111011, 8'b10110100, 8'b11110111,
    8'b11111000, 8'b11010110, 8'b11100110, 8'b00011010};

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic pulse_clr();
    flag_clr = 1'b1; tick(1); flag_clr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; pin_in = 1'b1; sense_sel = 2'b11; pin_mask = 1'b1;
    glob_ie = 1'b1; flag_clr = 1'b0; irq_taken = 1'b0; deep_sleep = 1'b0;
    tick(3);
    check("R1", "flag in reset", req_flag, 1'b0);
    check("R1", "line in reset", irq_line, 1'b0);
    rst_n = 1'b1;
    tick(6);
    check("R1", "flag after reset", req_flag, 1'b0);
    check("R1", "wake after reset", wake_req, 1'b0);

    // Table walk
    for (int i = 0; i < 12; i++) begin
      logic [7:0] v;
      string tag;
      v = VEC[i];
      case (v[7:6])
        2'b00:   tag = "R2";
        2'b01:   tag = "R3";
        2'b10:   tag = "R4";
        default: tag = "R5";
      endcase
      sense_sel = v[7:6]; pin_mask = v[5]; glob_ie = v[4]; pin_in = v[3];
      tick(6);
      pulse_clr();
      pin_in = v[2];
      tick(4);
      check(tag, "vector flag", req_flag, v[1]);
      check((v[5] && v[4]) ? tag : "R7", "vector line", irq_line, v[0]);
    end

    // R2 latency and no latching
    sense_sel = 2'b00; pin_mask = 1'b1; glob_ie = 1'b1; pin_in = 1'b1; tick(6);
    pin_in = 1'b0; tick(1);
    check("R2", "level after 1 edge", req_flag, 1'b0);
    tick(1);
    check("R2", "level after 2 edges", req_flag, 1'b1);
    pulse_clr();
    check("R2", "ack ignored in level", req_flag, 1'b1);
    pin_in = 1'b1; tick(2);
    check("R2", "level follows pin", req_flag, 1'b0);

    // R6 event beats clear on the same edge, then taken clears
    sense_sel = 2'b11; pin_in = 1'b0; tick(5); pulse_clr(); tick(1);
    pin_in = 1'b1; tick(2);
    check("R5", "no rise yet at edge 2", req_flag, 1'b0);
    flag_clr = 1'b1; tick(1); flag_clr = 1'b0;
    check("R6", "set wins over clear", req_flag, 1'b1);
    irq_taken = 1'b1; tick(1); irq_taken = 1'b0;
    check("R6", "taken clears", req_flag, 1'b0);

    // R8 masked edge, history updated
    sense_sel = 2'b10; pin_mask = 1'b0; tick(3);
    pin_in = 1'b0; tick(4);
    check("R8", "masked flag set", req_flag, 1'b1);
    check("R8", "masked line quiet", irq_line, 1'b0);
    pulse_clr();
    pin_mask = 1'b1; tick(5);
    check("R8", "no stale edge", req_flag, 1'b0);
    check("R8", "no stale line", irq_line, 1'b0);

    // R9 code changes
    pin_in = 1'b1; tick(6); pulse_clr(); tick(1);
    sense_sel = 2'b11; tick(5);
    check("R9", "steady pin code change", req_flag, 1'b0);
    pin_in = 1'b0; tick(5);
    check("R5", "fall ignored in rise code", req_flag, 1'b0);
    sense_sel = 2'b00;
    check("R9", "old code before edge", req_flag, 1'b0);
    tick(1);
    check("R9", "new code after edge", req_flag, 1'b1);
    sense_sel = 2'b11; pin_in = 1'b1; tick(4);
    check("R5", "rise sets", req_flag, 1'b1);
    sense_sel = 2'b00; tick(1);
    sense_sel = 2'b11; tick(1);
    check("R2", "level mode empties sticky", req_flag, 1'b0);

    // R10 level wake
    sense_sel = 2'b00; deep_sleep = 1'b1; pin_in = 1'b1; #300;
    check("R10", "idle no wake", wake_req, 1'b0);
    pin_in = 1'b0; #30; pin_in = 1'b1; #300;
    check("R10", "glitch rejected", wake_req, 1'b0);
    pin_in = 1'b0; #400;
    check("R10", "held low wakes", wake_req, 1'b1);
    pin_in = 1'b1; #300;
    check("R10", "released", wake_req, 1'b0);

    // R12 no wake under edge code or mask
    sense_sel = 2'b10; pin_in = 1'b0; #400;
    check("R12", "edge code no wake", wake_req, 1'b0);
    pin_in = 1'b1; #300;
    sense_sel = 2'b00; pin_mask = 1'b0; pin_in = 1'b0; #400;
    check("R12", "masked no wake", wake_req, 1'b0);
    pin_in = 1'b1; pin_mask = 1'b1; #300;

    // R11 change wake
    sense_sel = 2'b01; deep_sleep = 1'b0; #300;
    deep_sleep = 1'b1; #300;
    check("R11", "no change no wake", wake_req, 1'b0);
    pin_in = 1'b0; #400;
    check("R11", "change wakes", wake_req, 1'b1);
    deep_sleep = 1'b0; #300;
    check("R12", "awake no wake", wake_req, 1'b0);

    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule